// File: doc/BRIEF.md
# Store-to-Load Forwarding Overlap Classifier

This block sits beside a load/store queue and judges one load request against one older store entry. It compares the two byte ranges and sorts the pair into one of three classes: the store fully covers the load, the two ranges partly overlap, or they are disjoint. When the store fully covers the load, the block extracts the load's bytes from the store's data word so that the load can complete without a cache access. When they partly overlap, it can ask the pipeline to hold the load until the store has drained.

Load-linked loads and atomic stores never take the forwarding path. For those, any shared byte is reported as a partial overlap, so the load waits for memory rather than taking a possibly inconsistent copy of the data. A store entry whose valid bit is clear is treated as disjoint from every load.

The result is registered. A request pulse in one cycle produces a one-cycle response in the next. The response controller is a four-state machine. Idle means no response is being presented. Miss holds a disjoint verdict, Part holds a partial verdict with its stall decision, and Full holds a full-coverage verdict with the forwarded data. A request moves the machine from any state into Miss, Part or Full, depending on the verdict. A cycle without a request returns it to Idle.

Top module: `sfwd_classifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all outputs are zero: `rsp_valid`, `rsp_cov`, `fwd_valid`, `fwd_data` and `stall_req`.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was sampled high. When `rsp_valid` is low, `rsp_cov`, `fwd_valid`, `fwd_data` and `stall_req` are all zero.
- R3: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A range runs from its start address up to start plus size, with the end excluded. `rsp_cov` encodes disjoint as 0, partial as 1 and full as 2; the value 3 never appears. The result is full when all of the following hold:
  - the store is valid;
  - the load start is at or above the store start;
  - the load end is at or below the store end;
  - the store is not atomic;
  - the load is not load-linked.
- R4: For an ordinary load against an ordinary valid store, the result is partial when the result is not full and at least one byte is shared. Otherwise the result is disjoint.
- R5: A load-linked load never yields full. The result is partial when any byte is shared with a valid store, and disjoint otherwise.
- R6: An atomic store never yields full. The result is partial when any byte is shared with the load, and disjoint otherwise.
- R7: `fwd_valid` is high only with a full result. `fwd_data` is formed by moving the store data right by (load address minus store address) bytes. Bytes at and above the load size are zero, and `fwd_data` is zero whenever `fwd_valid` is low.
- R8: `stall_req` is high exactly when the result is partial and `st_done` was low at request time.
- R9: When `st_valid` is low, the result is disjoint with no forwarding and no stall, whatever the addresses are.
- R10: End addresses are computed one bit wider than the address. A range that runs past the top of the address space does not wrap around, and a load ending exactly at the store start is disjoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse; all other inputs are sampled with it |
| ld_addr | input | ADDR_W | Load start byte address |
| ld_size | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| ld_linked | input | 1 | Load is load-linked / store-conditional |
| st_valid | input | 1 | Store entry holds a live store |
| st_addr | input | ADDR_W | Store start byte address |
| st_size | input | 2 | Store size code |
| st_data | input | DATA_W | Store data, byte 0 at the store start address |
| st_atomic | input | 1 | Store belongs to an atomic operation |
| st_done | input | 1 | Store has already been written back |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_cov | output | 2 | Coverage code: 0 disjoint, 1 partial, 2 full |
| fwd_valid | output | 1 | `fwd_data` holds forwarded load data |
| fwd_data | output | DATA_W | Forwarded load data, zero-extended from the load size |
| stall_req | output | 1 | Hold the load until the store drains |

## Verification
The response to one request and the classification of the next request fall in the same cycle. The bench drives back-to-back request pulses with unrelated stores, so the machine moves directly between Full, Part and Miss without passing through Idle. In that situation, a stale data or stall register would leak into the following response. A behavioural reference model, built from byte counts, predicts every output on every clock. Any cycle in which the registered response lags or carries the previous verdict is counted as a mismatch against the requirement for the field that differs.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;

    localparam int SIZE_CODE_W = 2;

    typedef enum logic [1:0] {
        COV_NONE    = 2'd0,
        COV_PARTIAL = 2'd1,
        COV_FULL    = 2'd2
    } cov_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MISS = 2'd1,
        ST_PART = 2'd2,
        ST_FULL = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/sfwd_range_cmp.sv
module sfwd_range_cmp #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic [ADDR_W-1:0]                ld_addr,
    input  logic [sfwd_pkg::SIZE_CODE_W-1:0] ld_size,
    input  logic [ADDR_W-1:0]                st_addr,
    input  logic [sfwd_pkg::SIZE_CODE_W-1:0] st_size,
    output logic                             lo_limit_in,
    output logic                             hi_limit_in,
    output logic                             lo_part_hit,
    output logic                             hi_part_hit
);
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int BW         = $clog2(DATA_BYTES) + 1;
    localparam int EW         = ADDR_W + 1;

    logic [BW-1:0] ld_bytes;
    logic [BW-1:0] st_bytes;
    logic [EW-1:0] ld_start;
    logic [EW-1:0] ld_end;
    logic [EW-1:0] st_start;
    logic [EW-1:0] st_end;

    always_comb begin
        ld_bytes = BW'(1) << ld_size;
        st_bytes = BW'(1) << st_size;
        ld_start = {1'b0, ld_addr};
        st_start = {1'b0, st_addr};
        ld_end   = ld_start + EW'(ld_bytes);
        st_end   = st_start + EW'(st_bytes);
    end

    assign lo_limit_in = (ld_start >= st_start);
    assign hi_limit_in = (ld_end <= st_end);
    assign lo_part_hit = (ld_start < st_end);
    assign hi_part_hit = (ld_end > st_start);

endmodule

// File: rtl/sfwd_cov_decide.sv
module sfwd_cov_decide
    import sfwd_pkg::*;
(
    input  logic st_valid,
    input  logic ld_linked,
    input  logic st_atomic,
    input  logic lo_limit_in,
    input  logic hi_limit_in,
    input  logic lo_part_hit,
    input  logic hi_part_hit,
    output cov_e cov
);
    logic plain_partial;
    logic linked_partial;
    logic atomic_partial;
    logic any_shared;
    logic full_ok;

    always_comb begin
        any_shared     = (lo_limit_in || hi_part_hit) && (hi_limit_in || lo_part_hit);
        full_ok        = !st_atomic && lo_limit_in && hi_limit_in && !ld_linked;
        plain_partial  = !ld_linked &&
                         ((lo_limit_in && lo_part_hit) ||
                          (hi_limit_in && hi_part_hit) ||
                          (lo_part_hit && hi_part_hit));
        linked_partial = ld_linked && any_shared;
        atomic_partial = st_atomic && any_shared;

        cov = COV_NONE;
        if (st_valid) begin
            if (full_ok) begin
                cov = COV_FULL;
            end else if (plain_partial || linked_partial || atomic_partial) begin
                cov = COV_PARTIAL;
            end
        end
    end

endmodule

// File: rtl/sfwd_extract.sv
module sfwd_extract #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]                st_data,
    input  logic [$clog2(DATA_W/8)-1:0]      byte_off,
    input  logic [sfwd_pkg::SIZE_CODE_W-1:0] ld_size,
    output logic [DATA_W-1:0]                ld_data
);
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int BW         = $clog2(DATA_BYTES) + 1;

    logic [DATA_W-1:0] shifted;
    logic [BW-1:0]     keep_bytes;

    assign shifted    = st_data >> {byte_off, 3'b000};
    assign keep_bytes = BW'(1) << ld_size;

    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        localparam logic [BW-1:0] LANE = BW'(i);
        assign ld_data[8*i +: 8] = (LANE < keep_bytes) ? shifted[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/sfwd_classifier.sv
module sfwd_classifier
    import sfwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      ld_addr,
    input  logic [SIZE_CODE_W-1:0] ld_size,
    input  logic                   ld_linked,
    input  logic                   st_valid,
    input  logic [ADDR_W-1:0]      st_addr,
    input  logic [SIZE_CODE_W-1:0] st_size,
    input  logic [DATA_W-1:0]      st_data,
    input  logic                   st_atomic,
    input  logic                   st_done,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_cov,
    output logic                   fwd_valid,
    output logic [DATA_W-1:0]      fwd_data,
    output logic                   stall_req
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic             lo_limit_in;
    logic             hi_limit_in;
    logic             lo_part_hit;
    logic             hi_part_hit;
    cov_e             cov_now;
    logic [OFF_W-1:0] byte_off;
    logic [DATA_W-1:0] ld_data_now;

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] data_q;
    logic              stall_q;

    sfwd_range_cmp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) range_i (
        .ld_addr     (ld_addr),
        .ld_size     (ld_size),
        .st_addr     (st_addr),
        .st_size     (st_size),
        .lo_limit_in (lo_limit_in),
        .hi_limit_in (hi_limit_in),
        .lo_part_hit (lo_part_hit),
        .hi_part_hit (hi_part_hit)
    );

    sfwd_cov_decide decide_i (
        .st_valid    (st_valid),
        .ld_linked   (ld_linked),
        .st_atomic   (st_atomic),
        .lo_limit_in (lo_limit_in),
        .hi_limit_in (hi_limit_in),
        .lo_part_hit (lo_part_hit),
        .hi_part_hit (hi_part_hit),
        .cov         (cov_now)
    );

    assign byte_off = ld_addr[OFF_W-1:0] - st_addr[OFF_W-1:0];

    sfwd_extract #(
        .DATA_W (DATA_W)
    ) extract_i (
        .st_data  (st_data),
        .byte_off (byte_off),
        .ld_size  (ld_size),
        .ld_data  (ld_data_now)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            unique case (cov_now)
                COV_FULL:    state_d = ST_FULL;
                COV_PARTIAL: state_d = ST_PART;
                default:     state_d = ST_MISS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            stall_q <= 1'b0;
        end else begin
            state_q <= state_d;
            data_q  <= (req_valid && cov_now == COV_FULL) ? ld_data_now : '0;
            stall_q <= req_valid && (cov_now == COV_PARTIAL) && !st_done;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_cov   = COV_NONE;
        fwd_valid = 1'b0;
        fwd_data  = '0;
        stall_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
            end
            ST_PART: begin
                rsp_valid = 1'b1;
                rsp_cov   = COV_PARTIAL;
                stall_req = stall_q;
            end
            ST_FULL: begin
                rsp_valid = 1'b1;
                rsp_cov   = COV_FULL;
                fwd_valid = 1'b1;
                fwd_data  = data_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sfwd_classifier_chk.sv
module sfwd_classifier_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        ld_size,
    input logic              ld_linked,
    input logic              st_valid,
    input logic              st_atomic,
    input logic              rsp_valid,
    input logic [1:0]        rsp_cov,
    input logic              fwd_valid,
    input logic [DATA_W-1:0] fwd_data,
    input logic              stall_req,
    input logic [ADDR_W-1:0] ld_addr
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_cov == 2'd0 && !fwd_valid && !stall_req && fwd_data == '0));

    // R3
    cov_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cov != 2'd3);

    // R7
    fwd_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> rsp_cov == 2'd2);

    // R7
    byte_load_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ld_size == 2'd0) |=> fwd_data[DATA_W-1:8] == '0);

    // R8
    stall_only_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |-> rsp_cov == 2'd1);

    // R5
    linked_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ld_linked) |=> !fwd_valid);

    // R6
    atomic_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && st_atomic) |=> !fwd_valid);

    // R9
    dead_store_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !st_valid) |=> (rsp_cov == 2'd0 && !stall_req));

    logic unused_ok;
    assign unused_ok = ^ld_addr;

endmodule

bind sfwd_classifier sfwd_classifier_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ld_size   (ld_size),
    .ld_linked (ld_linked),
    .st_valid  (st_valid),
    .st_atomic (st_atomic),
    .rsp_valid (rsp_valid),
    .rsp_cov   (rsp_cov),
    .fwd_valid (fwd_valid),
    .fwd_data  (fwd_data),
    .stall_req (stall_req),
    .ld_addr   (ld_addr)
);

// File: tb/sfwd_classifier_tb.sv
module sfwd_classifier_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [1:0]        ld_size = '0;
    logic              ld_linked = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic              st_atomic = 1'b0;
    logic              st_done = 1'b0;
    logic              rsp_valid;
    logic [1:0]        rsp_cov;
    logic              fwd_valid;
    logic [DATA_W-1:0] fwd_data;
    logic              stall_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    logic              e_valid = 0;
    logic [1:0]        e_cov = 0;
    logic              e_fwd = 0;
    logic [DATA_W-1:0] e_data = 0;
    logic              e_stall = 0;

    always #5 clk = ~clk;

    sfwd_classifier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .ld_addr(ld_addr), .ld_size(ld_size), .ld_linked(ld_linked),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .st_data(st_data), .st_atomic(st_atomic), .st_done(st_done),
        .rsp_valid(rsp_valid), .rsp_cov(rsp_cov), .fwd_valid(fwd_valid),
        .fwd_data(fwd_data), .stall_req(stall_req)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: count shared bytes one address at a time.
    always @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            e_valid <= 0; e_cov <= 0; e_fwd <= 0; e_data <= 0; e_stall <= 0;
        end else begin
            int ls, le, ss, se, shared, lb;
            logic [1:0] c;
            logic [DATA_W-1:0] d;
            lb = 1 << ld_size;
            ls = int'(ld_addr); le = ls + lb;
            ss = int'(st_addr); se = ss + (1 << st_size);
            shared = 0;
            for (int a = ls; a < le; a++) if (a >= ss && a < se) shared++;
            c = 0; d = 0;
            if (st_valid) begin
                if (shared == lb && !st_atomic && !ld_linked) c = 2;
                else if (shared > 0) c = 1;
            end
            if (c == 2) for (int k = 0; k < lb; k++) d[8*k +: 8] = st_data[8*(ls - ss + k) +: 8];
            e_valid <= 1; e_cov <= c; e_fwd <= (c == 2); e_data <= d;
            e_stall <= (c == 1) && !st_done;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(rsp_valid == e_valid, "R2 rsp_valid", 64'(rsp_valid), 64'(e_valid));
            check(rsp_cov == e_cov, "R3 rsp_cov", 64'(rsp_cov), 64'(e_cov));
            check(fwd_valid == e_fwd, "R7 fwd_valid", 64'(fwd_valid), 64'(e_fwd));
            check(fwd_data == e_data, "R7 fwd_data", fwd_data, e_data);
            check(stall_req == e_stall, "R8 stall_req", 64'(stall_req), 64'(e_stall));
        end
    end

    task automatic issue(input logic [15:0] la, input logic [1:0] lz, input bit ll,
                         input bit sv, input logic [15:0] sa, input logic [1:0] sz,
                         input logic [63:0] sd, input bit at, input bit dn);
        @(negedge clk);
        req_valid = 1; ld_addr = la; ld_size = lz; ld_linked = ll;
        st_valid = sv; st_addr = sa; st_size = sz; st_data = sd;
        st_atomic = at; st_done = dn;
        @(negedge clk);
        req_valid = 0;
    endtask

    localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!rsp_valid && rsp_cov == 0 && !fwd_valid && fwd_data == 0 && !stall_req,
              "R1 reset outputs", {rsp_cov, 62'(fwd_data)}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        check(!rsp_valid && fwd_data == 0, "R1 first cycle", 64'(rsp_valid), 64'd0);

        issue(16'h0100, 2'd3, 0, 1, 16'h0100, 2'd3, PAT, 0, 0);
        check(rsp_cov == 2 && fwd_data == PAT, "R3 exact full", fwd_data, PAT);
        issue(16'h0103, 2'd1, 0, 1, 16'h0100, 2'd3, PAT, 0, 0);
        check(fwd_valid && fwd_data == 64'h5544, "R7 offset half", fwd_data, 64'h5544);
        issue(16'h0106, 2'd2, 0, 1, 16'h0100, 2'd3, PAT, 0, 0);
        check(rsp_cov == 1 && stall_req, "R4 straddle partial stall", {rsp_cov, stall_req}, 64'h3);
        issue(16'h0106, 2'd2, 0, 1, 16'h0100, 2'd3, PAT, 0, 1);
        check(rsp_cov == 1 && !stall_req, "R8 done store no stall", 64'(stall_req), 64'd0);
        issue(16'h00FC, 2'd2, 0, 1, 16'h0100, 2'd3, PAT, 0, 0);
        check(rsp_cov == 0 && rsp_valid, "R10 adjacent disjoint", 64'(rsp_cov), 64'd0);
        issue(16'h0100, 2'd3, 0, 1, 16'h0102, 2'd1, PAT, 0, 0);
        check(rsp_cov == 1, "R4 load wider than store", 64'(rsp_cov), 64'd1);
        issue(16'h0102, 2'd1, 1, 1, 16'h0100, 2'd3, PAT, 0, 1);
        check(rsp_cov == 1 && !fwd_valid && fwd_data == 0, "R5 linked inside", 64'(rsp_cov), 64'd1);
        issue(16'h0110, 2'd1, 1, 1, 16'h0100, 2'd3, PAT, 0, 0);
        check(rsp_cov == 0, "R5 linked disjoint", 64'(rsp_cov), 64'd0);
        issue(16'h0100, 2'd0, 0, 1, 16'h0100, 2'd2, PAT, 1, 0);
        check(rsp_cov == 1 && stall_req && !fwd_valid, "R6 atomic store", 64'(rsp_cov), 64'd1);
        issue(16'h0100, 2'd2, 0, 0, 16'h0100, 2'd3, PAT, 0, 0);
        check(rsp_cov == 0 && !stall_req && !fwd_valid, "R9 invalid store", 64'(rsp_cov), 64'd0);
        issue(16'hFFFC, 2'd2, 0, 1, 16'hFFF8, 2'd3, PAT, 0, 0);
        check(rsp_cov == 2 && fwd_data == 64'h8877_6655, "R10 top of space", fwd_data, 64'h8877_6655);
        issue(16'h0002, 2'd1, 0, 1, 16'hFFFC, 2'd3, PAT, 0, 0);
        check(rsp_cov == 0, "R10 no wrap", 64'(rsp_cov), 64'd0);
        @(negedge clk);
        check(!rsp_valid && rsp_cov == 0, "R2 idle after gap", 64'(rsp_valid), 64'd0);

        // Back-to-back mixed traffic, compared by the reference each clock.
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            req_valid = ($urandom_range(0, 3) != 0);
            ld_addr   = 16'h0200 + 16'($urandom_range(0, 23));
            ld_size   = 2'($urandom_range(0, 3));
            ld_linked = ($urandom_range(0, 5) == 0);
            st_valid  = ($urandom_range(0, 7) != 0);
            st_addr   = 16'h0200 + 16'($urandom_range(0, 23));
            st_size   = 2'($urandom_range(0, 3));
            st_data   = {$urandom, $urandom};
            st_atomic = ($urandom_range(0, 5) == 0);
            st_done   = $urandom_range(0, 1) == 1;
        end
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule